// File: doc/BRIEF.md
# Register-Cached Ray Traversal Stack

This block holds the traversal stack of one ray for a hardware bounding-volume-hierarchy walker. The newest few entries sit in a small register file, so a walker that pushes and pops near the top of its stack does not touch memory. When a push finds the register file full, the oldest resident entry is written to a backing store through a request/acknowledge port. A pop that finds the register file empty while older entries remain in the store reads one back on demand.

Each entry is a node index whose upper bits name the treelet the node belongs to, and the block splits that field out on every pop. When the ray is suspended, a flush command writes every resident entry to the backing store. A restore command later resumes the ray with only the saved depth: the register file starts empty, and entries come back through refills as the walker pops. Every memory access moves exactly one transfer unit of 32 bytes, with the entry zero-padded inside it.

Top module: `stk_top`

## Requirements
- R1: After reset, cmd_ready is 1, depth is 0, and mem_req, pop_valid and pop_underflow are 0.
- R2: A push (cmd_op 0) accepted while fewer than four entries are resident completes without a memory access and raises depth by one.
- R3: A push accepted with four entries resident writes the oldest resident entry to address depth minus four. mem_req, mem_we, mem_addr and mem_wdata hold until mem_ack, and cmd_ready stays 0 while a request is open.
- R4: Each memory word is 256 bits. The 32-bit entry occupies bits 31:0 and bits 255:32 are written as zero.
- R5: A pop (cmd_op 1) accepted with at least one resident entry raises pop_valid for one cycle on the following cycle, with the most recently pushed entry on pop_data.
- R6: A pop accepted with no resident entries and a non-zero depth issues a read of address depth minus one on the next cycle. pop_valid rises for one cycle only on the cycle after mem_ack, with the returned bits 31:0.
- R7: A pop accepted at depth 0 raises pop_underflow for one cycle on the next cycle, with no pop_valid, no memory access and no change of depth.
- R8: A flush (cmd_op 2) writes all resident entries, oldest first, to consecutive addresses starting at depth minus the resident count. Depth does not change and the register file is left empty.
- R9: A restore (cmd_op 3) sets depth to restore_depth and empties the register file on the next cycle. Later pops refill from addresses restore_depth minus one downward.
- R10: pop_treelet equals bits 31:18 of pop_data whenever pop_valid is 1.
- R11: Across any mix of push, pop, flush and restore, pops return entries in last-in-first-out order, and depth equals the number of stored entries whenever cmd_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Command strobe, taken when cmd_ready is 1 |
| cmd_op | input | 2 | 0 push, 1 pop, 2 flush, 3 restore |
| cmd_data | input | 32 | Entry to push |
| restore_depth | input | 7 | Depth to resume from on restore |
| cmd_ready | output | 1 | Block idle and able to take a command |
| depth | output | 7 | Total stored entries, registers plus memory |
| pop_valid | output | 1 | One-cycle pop result strobe |
| pop_data | output | 32 | Popped entry |
| pop_treelet | output | 14 | Treelet field of the popped entry |
| pop_underflow | output | 1 | One-cycle strobe for a pop on an empty stack |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 write (spill or flush), 0 read (refill) |
| mem_addr | output | 7 | Entry slot address in transfer units |
| mem_wdata | output | 256 | Write data, one transfer unit |
| mem_ack | input | 1 | One-cycle acknowledge of the open request |
| mem_rdata | input | 256 | Read data, valid with mem_ack |

## Verification
The assertions assume that mem_ack is pulsed only while mem_req is high, for one cycle per request, and that pushes never take depth past its 64-entry limit. They also assume a restore follows a flush, so the backing store holds the entries it resumes. The responder in the bench acknowledges only an open request, after a random or forced delay, and drops its acknowledge on the next cycle. The random sequence caps the model depth well below the limit and issues restore only right after a flush, with a depth no larger than the flushed one.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_PUSH    = 2'd0,
    OP_POP     = 2'd1,
    OP_FLUSH   = 2'd2,
    OP_RESTORE = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SPILL,
    S_FLUSH,
    S_REFILL
  } stk_state_e;
endpackage

// File: rtl/stk_resident.sv
module stk_resident #(
  parameter int W   = 32,
  parameter int RES = 4,
  localparam int CW = $clog2(RES + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          push,
  input  logic          pop,
  input  logic          drop_old,
  input  logic          clear,
  input  logic [W-1:0]  wdata,
  output logic [CW-1:0] cnt,
  output logic [W-1:0]  top,
  output logic [W-1:0]  oldest
);
  // Slot 0 holds the oldest resident entry, slot cnt-1 the newest.
  logic [W-1:0]  slot_q [RES];
  logic [CW-1:0] cnt_q, cnt_d, cnt_b;
  logic          slot_en;

  assign cnt_b   = drop_old ? cnt_q - CW'(1) : cnt_q;
  assign slot_en = push | drop_old;

  for (genvar g = 0; g < RES; g++) begin : g_slot
    logic [W-1:0] shifted, nxt, q;
    if (g < RES - 1) begin : g_mid
      assign shifted = slot_q[g+1];
    end else begin : g_last
      assign shifted = q;
    end
    always_comb begin
      nxt = drop_old ? shifted : q;
      if (push && cnt_b == CW'(g)) nxt = wdata;
    end
    always_ff @(posedge clk) begin
      if (slot_en) q <= nxt;
    end
    assign slot_q[g] = q;
  end

  always_comb begin
    if (clear)     cnt_d = '0;
    else if (pop)  cnt_d = cnt_q - CW'(1);
    else if (push) cnt_d = cnt_b + CW'(1);
    else           cnt_d = cnt_b;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  always_comb begin
    top = slot_q[0];
    for (int i = 0; i < RES; i++) begin
      if (cnt_q == CW'(i + 1)) top = slot_q[i];
    end
  end

  assign oldest = slot_q[0];
  assign cnt    = cnt_q;
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int W   = 32,
  parameter int RES = 4,
  parameter int AW  = 7,
  parameter int XW  = 256,
  localparam int CW = $clog2(RES + 1)
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [W-1:0]  cmd_data,
  input  logic [AW-1:0] restore_depth,
  output logic          cmd_ready,
  input  logic [CW-1:0] res_cnt,
  input  logic [W-1:0]  res_top,
  input  logic [W-1:0]  res_old,
  output logic          rf_push,
  output logic          rf_pop,
  output logic          rf_drop,
  output logic          rf_clear,
  output logic [W-1:0]  rf_wdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [XW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [XW-1:0] mem_rdata,
  output logic          pop_valid,
  output logic [W-1:0]  pop_data,
  output logic          pop_underflow,
  output logic [AW-1:0] depth
);
  stk_state_e    st_q, st_d;
  logic [AW-1:0] mp_q, mp_d;     // entries held in backing memory
  logic [AW-1:0] tot_q, tot_d;   // total stack depth
  logic [W-1:0]  pend_q;
  logic          pend_en;
  logic          pv_q, pv_d, uf_q, uf_d;
  logic [W-1:0]  pd_q, pd_d;
  logic          unused_pad;

  assign unused_pad = ^mem_rdata[XW-1:W];

  always_comb begin
    st_d = st_q; mp_d = mp_q; tot_d = tot_q; pend_en = 1'b0;
    rf_push = 1'b0; rf_pop = 1'b0; rf_drop = 1'b0; rf_clear = 1'b0;
    pv_d = 1'b0; pd_d = res_top; uf_d = 1'b0;
    mem_req = 1'b0; mem_we = 1'b0;
    unique case (st_q)
      S_IDLE: if (cmd_valid) begin
        unique case (cmd_op)
          OP_PUSH: begin
            if (res_cnt == CW'(RES)) begin
              st_d = S_SPILL; pend_en = 1'b1;
            end else begin
              rf_push = 1'b1; tot_d = tot_q + AW'(1);
            end
          end
          OP_POP: begin
            if (tot_q == '0) uf_d = 1'b1;
            else if (res_cnt != '0) begin
              rf_pop = 1'b1; pv_d = 1'b1; tot_d = tot_q - AW'(1);
            end else st_d = S_REFILL;
          end
          OP_FLUSH: if (res_cnt != '0) st_d = S_FLUSH;
          default: begin
            rf_clear = 1'b1; mp_d = restore_depth; tot_d = restore_depth;
          end
        endcase
      end
      S_SPILL: begin
        mem_req = 1'b1; mem_we = 1'b1;
        if (mem_ack) begin
          rf_drop = 1'b1; rf_push = 1'b1;
          mp_d = mp_q + AW'(1); tot_d = tot_q + AW'(1); st_d = S_IDLE;
        end
      end
      S_FLUSH: begin
        mem_req = 1'b1; mem_we = 1'b1;
        if (mem_ack) begin
          rf_drop = 1'b1; mp_d = mp_q + AW'(1);
          if (res_cnt == CW'(1)) st_d = S_IDLE;
        end
      end
      default: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          pv_d = 1'b1; pd_d = mem_rdata[W-1:0];
          mp_d = mp_q - AW'(1); tot_d = tot_q - AW'(1); st_d = S_IDLE;
        end
      end
    endcase
  end

  assign rf_wdata  = (st_q == S_SPILL) ? pend_q : cmd_data;
  assign mem_addr  = (st_q == S_REFILL) ? mp_q - AW'(1) : mp_q;
  assign mem_wdata = XW'(res_old);
  assign cmd_ready = (st_q == S_IDLE);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; mp_q <= '0; tot_q <= '0; pv_q <= 1'b0; uf_q <= 1'b0;
    end else begin
      st_q <= st_d; mp_q <= mp_d; tot_q <= tot_d; pv_q <= pv_d; uf_q <= uf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pend_en) pend_q <= cmd_data;
    if (pv_d)    pd_q   <= pd_d;
  end

  assign pop_valid     = pv_q;
  assign pop_data      = pd_q;
  assign pop_underflow = uf_q;
  assign depth         = tot_q;
endmodule

// File: rtl/stk_top.sv
module stk_top #(
  parameter int ENTRY_W    = 32,
  parameter int TREELET_W  = 14,
  parameter int RES_DEPTH  = 4,
  parameter int DEPTH_MAX  = 64,
  parameter int XFER_BYTES = 32,
  localparam int XW = XFER_BYTES * 8,
  localparam int AW = $clog2(DEPTH_MAX + 1),
  localparam int CW = $clog2(RES_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [ENTRY_W-1:0]   cmd_data,
  input  logic [AW-1:0]        restore_depth,
  output logic                 cmd_ready,
  output logic [AW-1:0]        depth,
  output logic                 pop_valid,
  output logic [ENTRY_W-1:0]   pop_data,
  output logic [TREELET_W-1:0] pop_treelet,
  output logic                 pop_underflow,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [AW-1:0]        mem_addr,
  output logic [XW-1:0]        mem_wdata,
  input  logic                 mem_ack,
  input  logic [XW-1:0]        mem_rdata
);
  logic [1:0]         rst_sync;
  logic               rst_ni;
  logic [CW-1:0]      res_cnt;
  logic [ENTRY_W-1:0] res_top, res_old, rf_wdata;
  logic               rf_push, rf_pop, rf_drop, rf_clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  stk_resident #(.W(ENTRY_W), .RES(RES_DEPTH)) u_res (
    .clk(clk), .rst_ni(rst_ni), .push(rf_push), .pop(rf_pop),
    .drop_old(rf_drop), .clear(rf_clear), .wdata(rf_wdata),
    .cnt(res_cnt), .top(res_top), .oldest(res_old)
  );

  stk_ctrl #(.W(ENTRY_W), .RES(RES_DEPTH), .AW(AW), .XW(XW)) u_ctrl (
    .clk(clk), .rst_ni(rst_ni), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .restore_depth(restore_depth), .cmd_ready(cmd_ready),
    .res_cnt(res_cnt), .res_top(res_top), .res_old(res_old),
    .rf_push(rf_push), .rf_pop(rf_pop), .rf_drop(rf_drop), .rf_clear(rf_clear),
    .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_underflow(pop_underflow),
    .depth(depth)
  );

  assign pop_treelet = pop_data[ENTRY_W-1 -: TREELET_W];
endmodule

// File: rtl/stk_top_chk.sv
module stk_top_chk #(
  parameter int W   = 32,
  parameter int XW  = 256,
  parameter int AW  = 7,
  parameter int CW  = 3,
  parameter int RES = 4
) (
  input logic          clk,
  input logic          rst_ni,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [1:0]    cmd_op,
  input logic [AW-1:0] restore_depth,
  input logic [CW-1:0] res_cnt,
  input logic [AW-1:0] depth,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [XW-1:0] mem_wdata,
  input logic          mem_ack,
  input logic          pop_valid,
  input logic          pop_underflow
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  p_resident_push_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && cmd_op == 2'd0 && res_cnt < CW'(RES) |=> !mem_req);

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

  p_busy_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req |-> !cmd_ready);

  p_pad_zero_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && mem_we |-> mem_wdata[XW-1:W] == '0);

  p_pop_resident_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && cmd_op == 2'd1 && res_cnt != '0 |=> pop_valid && !mem_req);

  p_refill_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && cmd_op == 2'd1 && res_cnt == '0 && depth != '0
    |=> mem_req && !mem_we && !pop_valid && mem_addr == $past(depth) - AW'(1));

  p_underflow_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && cmd_op == 2'd1 && depth == '0 |=> pop_underflow && !pop_valid && !mem_req && depth == '0);

  p_flush_depth_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && cmd_op == 2'd2 |=> depth == $past(depth));

  p_restore_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    acc && cmd_op == 2'd3 |=> depth == $past(restore_depth) && res_cnt == '0);

  p_write_slot_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    mem_req && mem_we |-> ({1'b0, mem_addr} + (AW+1)'(res_cnt)) == {1'b0, depth});

  p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    !(pop_valid && pop_underflow));
endmodule

bind stk_top stk_top_chk #(.W(ENTRY_W), .XW(XW), .AW(AW), .CW(CW), .RES(RES_DEPTH)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .restore_depth(restore_depth), .res_cnt(res_cnt), .depth(depth),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .pop_valid(pop_valid), .pop_underflow(pop_underflow)
);

// File: tb/sim_stk_top.sv
module sim_stk_top;
  localparam int W  = 32;
  localparam int TW = 14;
  localparam int DM = 64;
  localparam int XW = 256;
  localparam int AW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [1:0]    cmd_op = 2'd0;
  logic [W-1:0]  cmd_data = '0;
  logic [AW-1:0] restore_depth = '0;
  logic          cmd_ready, pop_valid, pop_underflow, mem_req, mem_we;
  logic [AW-1:0] depth, mem_addr;
  logic [W-1:0]  pop_data;
  logic [TW-1:0] pop_treelet;
  logic [XW-1:0] mem_wdata;
  logic          mem_ack = 1'b0;
  logic [XW-1:0] mem_rdata = '0;

  stk_top u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .restore_depth(restore_depth), .cmd_ready(cmd_ready),
    .depth(depth), .pop_valid(pop_valid), .pop_data(pop_data),
    .pop_treelet(pop_treelet), .pop_underflow(pop_underflow), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  int model[$];
  int exp_kind[$];       // 0 data, 1 underflow
  int exp_val[$];
  logic [XW-1:0] bmem [DM];
  int n_wr = 0, n_rd = 0, last_waddr = -1, last_raddr = -1;
  int fixed_delay = 1, wait_cnt = 0;
  bit running = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Behavioural memory responder.
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt > 0) wait_cnt--;
      else begin
        if (mem_we) begin
          bmem[mem_addr] = mem_wdata; n_wr++; last_waddr = int'(mem_addr);
        end else begin
          mem_rdata = bmem[mem_addr]; n_rd++; last_raddr = int'(mem_addr);
        end
        mem_ack = 1'b1;
        wait_cnt = (fixed_delay >= 0) ? fixed_delay : $urandom_range(0, 3);
      end
    end
  end

  // Output monitor against the reference expectations.
  always @(negedge clk) begin
    if (running) begin
      if (pop_valid) begin
        if (exp_kind.size() == 0 || exp_kind[0] != 0) begin
          chk(0, "R11", "unexpected pop_valid", pop_data, 0);
        end else begin
          chk(pop_data == W'(exp_val[0]), "R5/R6/R11", "pop order", pop_data, exp_val[0]);
          chk(pop_treelet == exp_val[0][W-1 -: TW], "R10", "treelet field",
              pop_treelet, exp_val[0][W-1 -: TW]);
          void'(exp_kind.pop_front()); void'(exp_val.pop_front());
        end
      end
      if (pop_underflow) begin
        chk(exp_kind.size() != 0 && exp_kind[0] == 1, "R7", "unexpected underflow", 1, 0);
        if (exp_kind.size() != 0) begin
          void'(exp_kind.pop_front()); void'(exp_val.pop_front());
        end
      end
      if (mem_req && cmd_ready) chk(0, "R3", "ready while request open", 1, 0);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R11 run did not complete actual=1 expected=0");
    finish_run();
  end

  task automatic do_cmd(input int op, input int data, input int rd);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_data = W'(data); restore_depth = AW'(rd);
    case (op)
      0: model.push_back(data);
      1: begin
        if (model.size() == 0) begin exp_kind.push_back(1); exp_val.push_back(0); end
        else begin exp_kind.push_back(0); exp_val.push_back(model.pop_back()); end
      end
      3: while (model.size() > rd) void'(model.pop_back());
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic settle(input string req);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    chk(int'(depth) == model.size(), req, "depth", depth, model.size());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    running = 1'b1;
    chk(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);
    chk(depth == '0, "R1", "depth after reset", depth, 0);
    chk(!mem_req && !pop_valid && !pop_underflow, "R1", "quiet outputs",
        {mem_req, pop_valid, pop_underflow}, 0);

    // R7: pop on empty
    do_cmd(1, 0, 0); settle("R7");
    chk(n_rd == 0 && n_wr == 0, "R7", "no memory access", n_rd + n_wr, 0);

    // R2: four resident pushes
    for (int i = 0; i < 4; i++) do_cmd(0, 32'h1000_0000 * (i + 1) + i, 0);
    settle("R2");
    chk(n_wr == 0, "R2", "no spill for four entries", n_wr, 0);

    // R3/R4: fifth push spills oldest
    fixed_delay = 3;
    do_cmd(0, 32'hABCD_0005, 0);
    chk(cmd_ready == 1'b0, "R3", "ready low during spill", cmd_ready, 0);
    settle("R3");
    chk(n_wr == 1 && last_waddr == 0, "R3", "spill address", last_waddr, 0);
    chk(bmem[0][W-1:0] == 32'h1000_0000, "R3", "spilled entry", bmem[0][W-1:0], 32'h1000_0000);
    chk(bmem[0][XW-1:W] == '0, "R4", "padding zero", bmem[0][XW-1:W] != '0, 0);

    // R5/R6: drain, last pop refills from address 0
    fixed_delay = 2;
    for (int i = 0; i < 4; i++) do_cmd(1, 0, 0);
    settle("R5");
    chk(n_rd == 0, "R5", "resident pops need no read", n_rd, 0);
    do_cmd(1, 0, 0);
    settle("R6");
    chk(n_rd == 1 && last_raddr == 0, "R6", "refill address", last_raddr, 0);

    // R8: six pushes then flush
    for (int i = 0; i < 6; i++) do_cmd(0, 32'h7700_0000 + i * 3, 0);
    settle("R8");
    n_wr = 0;
    do_cmd(2, 0, 0); settle("R8");
    chk(n_wr == 4, "R8", "flush writes resident entries", n_wr, 4);
    for (int i = 2; i < 6; i++)
      chk(bmem[i][W-1:0] == W'(model[i]), "R8", "flushed slot", bmem[i][W-1:0], model[i]);

    // R9: restore full depth then truncated
    do_cmd(3, 0, 6); settle("R9");
    do_cmd(1, 0, 0); settle("R9");
    chk(last_raddr == 5, "R9", "first refill after restore", last_raddr, 5);
    do_cmd(2, 0, 0); do_cmd(3, 0, 3); settle("R9");
    do_cmd(1, 0, 0); settle("R9");
    chk(last_raddr == 2, "R9", "refill after truncated restore", last_raddr, 2);

    // R11: random sequence with random memory latency
    fixed_delay = -1;
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      if (model.size() >= 40) r = 60;
      if (r < 48) do_cmd(0, int'($urandom), 0);
      else if (r < 92) do_cmd(1, 0, 0);
      else begin
        do_cmd(2, 0, 0);
        if ($urandom_range(0, 1) == 1) do_cmd(3, 0, $urandom_range(0, model.size()));
      end
      if (n % 50 == 0) settle("R11");
    end
    settle("R11");
    repeat (3) @(negedge clk);
    chk(exp_kind.size() == 0, "R11", "outstanding pops", exp_kind.size(), 0);
    finish_run();
  end
endmodule